// File: doc/BRIEF.md
# Serial Transmitter with Break and Idle-Frame Insertion

This block serialises words onto an asynchronous serial line. Software or a bus decoder writes a word into a single holding register. At the next bit tick the sequencer moves the word into its own frame registers. It then sends the frame as a low start bit, 8 or 9 data bits with the least significant bit first, and a high stop bit. One bit is sent per pulse of the bit-tick input, and baud-rate generation happens outside the block.

The sequencer can also send two other kinds of frame. The first is a break: the line is held low for a programmable number of bit times and then released high for one stop bit. The second is a preamble: one frame-length of idle-high bits. Both kinds are requested while a frame is on the line and start only when that frame ends. A LIN master mode makes the break low phase longer. Two status flags report when the holding register is empty and when transmission is complete, and each flag has its own interrupt enable.

Top module: `uart_brk_tx`

## Requirements
- R1: A data frame is one low start bit, then N data bits with the least significant bit first, then one high stop bit. N is 9 when `word9` is 1 and 8 when it is 0. The line is high while idle.
- R2: With `lin_mode` at 0, a break holds the line low for 10 bit times (`word9`=0) or 11 bit times (`word9`=1), followed by one high bit.
- R3: With `lin_mode` at 1, the break low phase lasts 13 bit times (`word9`=0) or 14 bit times (`word9`=1), followed by one high bit.
- R4: A 1-then-0 pulse on `send_brk` while a frame is on the line causes exactly one break, which starts when that frame ends.
- R5: While `send_brk` stays at 1, breaks are sent back to back. Once it returns to 0, no further break is sent.
- R6: `txd_oe` equals `tx_en`. No new frame starts while `tx_en` is 0.
- R7: A 0-then-1 pulse on `tx_en` while a frame is on the line queues one preamble. The preamble is N+2 high bits with no start bit and follows the current frame.
- R8: A write (`wr_valid`) clears `hold_empty` and `tx_done`. `hold_empty` returns to 1 at the bit tick on which the word starts to be sent.
- R9: After reset, `hold_empty`=1, `tx_done`=1 and `txd`=1. `tx_done` sets when the last bit of a frame ends, no other frame follows, and the holding register is empty. `tx_done` is never 1 while `hold_empty` is 0.
- R10: `irq` = (`hold_empty` AND `tdre_ie`) OR (`tx_done` AND `tc_ie`).
- R11: When several requests are waiting at a frame boundary, they are served in this order: a pending break first, then a pending preamble, then the word in the holding register.
- R12: `txd` changes only on a clock edge where `bit_tick` is 1, and frames start only on such edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmit enable; a 0-then-1 pulse during a frame queues a preamble |
| send_brk | input | 1 | Break request |
| lin_mode | input | 1 | Selects the longer LIN break |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send; bit 8 is used only in 9-bit mode |
| tdre_ie | input | 1 | Interrupt enable for the empty flag |
| tc_ie | input | 1 | Interrupt enable for the complete flag |
| txd | output | 1 | Serial line value |
| txd_oe | output | 1 | Line drive enable; 0 means the line is tri-stated |
| hold_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Transmission complete |
| irq | output | 1 | Interrupt request |

## Verification
The checks assume that `bit_tick` is a single-cycle pulse with at least two idle cycles between pulses. They also assume that control inputs change only between ticks, and that the holding register is written only while it is empty, so no queued word is ever overwritten. The bench generates ticks every five clocks and applies every write and every `send_brk` or `tx_en` pulse in the middle of a bit period. Before each new word it waits for `hold_empty`, or for the previous frame to finish, so all stimulus stays within those assumptions.

// File: rtl/utx_pkg.sv
// Shared types for the serial transmitter.
// Assumes nothing beyond being compiled before the modules that use it.
package utx_pkg;
    // Kind of frame currently occupying the line
    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_DATA = 2'd1,
        FR_BRK  = 2'd2,
        FR_PRE  = 2'd3
    } frame_e;
endpackage

// File: rtl/utx_req_ctrl.sv
// Request capture: holds the single-word buffer and the pending break and
// preamble requests. Assumes take_* pulses come from the sequencer at a
// frame boundary, and at most one of them is high in a cycle.
module utx_req_ctrl #(
    parameter int WIDE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WIDE_W-1:0] wr_data,
    input  logic              send_brk,
    input  logic              tx_en,
    input  logic              active,
    input  logic              take_data,
    input  logic              take_brk,
    input  logic              take_pre,
    output logic              hold_full,
    output logic [WIDE_W-1:0] hold_data,
    output logic              brk_due,
    output logic              pre_due
);
    logic brk_q, en_q, brk_pend, pre_pend;

    // Holding register: a write fills it, and the sequencer empties it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (wr_valid) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end else if (take_data) begin
            hold_full <= 1'b0;
        end
    end

    // Previous values of the control inputs, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            brk_q <= send_brk;
            en_q  <= tx_en;
        end
    end

    // A rising break request stays pending until a break frame starts
    always_ff @(posedge clk) begin
        if (!rst_n)                  brk_pend <= 1'b0;
        else if (take_brk)           brk_pend <= 1'b0;
        else if (send_brk && !brk_q) brk_pend <= 1'b1;
    end

    // A re-enable during a frame leaves one preamble pending
    always_ff @(posedge clk) begin
        if (!rst_n)                         pre_pend <= 1'b0;
        else if (take_pre)                  pre_pend <= 1'b0;
        else if (tx_en && !en_q && active)  pre_pend <= 1'b1;
    end

    assign brk_due = send_brk | brk_pend;
    assign pre_due = pre_pend;
endmodule

// File: rtl/utx_frame_seq.sv
// Frame sequencer: chooses the next frame at each boundary and sends it
// one bit per tick. Assumes bit_tick is a single-cycle pulse. The line value
// is decoded from registered state, so it changes only on tick edges.
module utx_frame_seq
    import utx_pkg::*;
#(
    parameter int NARROW_W  = 8,
    parameter int WIDE_W    = 9,
    parameter int LIN_EXTRA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              word9,
    input  logic              lin_mode,
    input  logic              brk_due,
    input  logic              pre_due,
    input  logic              hold_full,
    input  logic [WIDE_W-1:0] hold_data,
    output logic              txd_o,
    output logic              active,
    output logic              take_data,
    output logic              take_brk,
    output logic              take_pre,
    output logic              go_idle
);
    localparam int MAX_LOW = WIDE_W + 2 + LIN_EXTRA;
    localparam int CNT_W   = $clog2(MAX_LOW + 1);
    localparam logic [CNT_W-1:0] N_BITS = CNT_W'(NARROW_W);
    localparam logic [CNT_W-1:0] W_BITS = CNT_W'(WIDE_W);
    localparam logic [CNT_W-1:0] N_FR   = CNT_W'(NARROW_W + 2);
    localparam logic [CNT_W-1:0] W_FR   = CNT_W'(WIDE_W + 2);
    localparam logic [CNT_W-1:0] LX     = CNT_W'(LIN_EXTRA);

    frame_e            kind, nxt;
    logic [CNT_W-1:0]  cnt, lowlen, nbits, last;
    logic [WIDE_W-1:0] dat;
    logic              wide, boundary, step;

    // Frame geometry for the frame in progress
    always_comb begin
        nbits = wide ? W_BITS : N_BITS;
        last  = (kind == FR_BRK) ? lowlen : nbits + CNT_W'(1);
    end

    // Boundary decision: break first, then preamble, then data
    always_comb begin
        boundary = (kind == FR_IDLE) || (cnt == last);
        if (!tx_en)         nxt = FR_IDLE;
        else if (brk_due)   nxt = FR_BRK;
        else if (pre_due)   nxt = FR_PRE;
        else if (hold_full) nxt = FR_DATA;
        else                nxt = FR_IDLE;
        step      = bit_tick && boundary;
        take_brk  = step && (nxt == FR_BRK);
        take_pre  = step && (nxt == FR_PRE);
        take_data = step && (nxt == FR_DATA);
        go_idle   = step && (kind != FR_IDLE) && (nxt == FR_IDLE);
    end

    // Frame state: load at a boundary, advance one bit per tick otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind   <= FR_IDLE;
            cnt    <= '0;
            dat    <= '0;
            wide   <= 1'b0;
            lowlen <= N_FR;
        end else if (step) begin
            kind   <= nxt;
            cnt    <= '0;
            wide   <= word9;
            lowlen <= (word9 ? W_FR : N_FR) + (lin_mode ? LX : '0);
            if (nxt == FR_DATA) dat <= hold_data;
        end else if (bit_tick && kind != FR_IDLE) begin
            cnt <= cnt + CNT_W'(1);
            if (kind == FR_DATA && cnt != '0) dat <= dat >> 1;
        end
    end

    // Line value from frame kind and bit position
    always_comb begin
        case (kind)
            FR_DATA: begin
                if (cnt == '0)          txd_o = 1'b0;
                else if (cnt <= nbits)  txd_o = dat[0];
                else                    txd_o = 1'b1;
            end
            FR_BRK:  txd_o = (cnt >= lowlen);
            default: txd_o = 1'b1;
        endcase
    end

    assign active = (kind != FR_IDLE);
endmodule

// File: rtl/utx_status.sv
// Status flags and interrupt request. Assumes go_idle is high only at the
// tick on which the last frame ends with nothing following it.
module utx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic hold_full,
    input  logic go_idle,
    input  logic tdre_ie,
    input  logic tc_ie,
    output logic hold_empty,
    output logic tx_done,
    output logic irq
);
    // Complete flag: set when the line goes idle, cleared by a write
    always_ff @(posedge clk) begin
        if (!rst_n)                     tx_done <= 1'b1;
        else if (wr_valid)              tx_done <= 1'b0;
        else if (go_idle && !hold_full) tx_done <= 1'b1;
    end

    assign hold_empty = !hold_full;
    assign irq        = (hold_empty && tdre_ie) || (tx_done && tc_ie);
endmodule

// File: rtl/uart_brk_tx.sv
// Top level of the serial transmitter. Connects request capture, the frame
// sequencer and the status logic. Assumes an external bit-rate tick and a
// pad that uses txd_oe as its drive enable.
module uart_brk_tx #(
    parameter int NARROW_W  = 8,
    parameter int WIDE_W    = 9,
    parameter int LIN_EXTRA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              send_brk,
    input  logic              lin_mode,
    input  logic              word9,
    input  logic              wr_valid,
    input  logic [WIDE_W-1:0] wr_data,
    input  logic              tdre_ie,
    input  logic              tc_ie,
    output logic              txd,
    output logic              txd_oe,
    output logic              hold_empty,
    output logic              tx_done,
    output logic              irq
);
    logic              hold_full, brk_due, pre_due, active;
    logic              take_data, take_brk, take_pre, go_idle;
    logic [WIDE_W-1:0] hold_data;

    utx_req_ctrl #(.WIDE_W(WIDE_W)) u_req (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .send_brk(send_brk), .tx_en(tx_en), .active(active),
        .take_data(take_data), .take_brk(take_brk), .take_pre(take_pre),
        .hold_full(hold_full), .hold_data(hold_data),
        .brk_due(brk_due), .pre_due(pre_due)
    );

    utx_frame_seq #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .LIN_EXTRA(LIN_EXTRA)) u_seq (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .word9(word9), .lin_mode(lin_mode), .brk_due(brk_due),
        .pre_due(pre_due), .hold_full(hold_full), .hold_data(hold_data),
        .txd_o(txd), .active(active), .take_data(take_data),
        .take_brk(take_brk), .take_pre(take_pre), .go_idle(go_idle)
    );

    utx_status u_stat (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .hold_full(hold_full),
        .go_idle(go_idle), .tdre_ie(tdre_ie), .tc_ie(tc_ie),
        .hold_empty(hold_empty), .tx_done(tx_done), .irq(irq)
    );

    assign txd_oe = tx_en;
endmodule

// File: rtl/utx_chk.sv
// Property checker for the serial transmitter, attached by bind.
// Assumes the default frame widths of the top module.
module utx_chk #(
    parameter int WIDE_W    = 9,
    parameter int LIN_EXTRA = 3
) (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic wr_valid,
    input logic tdre_ie,
    input logic tc_ie,
    input logic txd,
    input logic hold_empty,
    input logic tx_done,
    input logic irq
);
    localparam int MAX_LOW = WIDE_W + 2 + LIN_EXTRA;
    logic [7:0] low_run;

    // Counts consecutive low bit periods on the line
    always_ff @(posedge clk) begin
        if (!rst_n)        low_run <= '0;
        else if (bit_tick) low_run <= txd ? 8'd0 : low_run + 8'd1;
    end

    // R8
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (!hold_empty && !tx_done));
    // R9
    done_implies_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> hold_empty);
    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tdre_ie && !tc_ie) |-> !irq);
    // R10
    irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_empty && tdre_ie) |-> irq);
    // R12
    line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd));
    // R3
    low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= 8'(MAX_LOW));
endmodule

bind uart_brk_tx utx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_valid(wr_valid),
    .tdre_ie(tdre_ie), .tc_ie(tc_ie), .txd(txd), .hold_empty(hold_empty),
    .tx_done(tx_done), .irq(irq)
);

// File: tb/uart_brk_tx_test.sv
module uart_brk_tx_test;
    localparam int CLK_P = 10;
    localparam int TPB   = 5;

    logic       clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0;
    logic       tx_en = 1'b1, send_brk = 1'b0, lin_mode = 1'b0, word9 = 1'b0;
    logic       wr_valid = 1'b0, tdre_ie = 1'b0, tc_ie = 1'b0;
    logic [8:0] wr_data = '0;
    logic       txd, txd_oe, hold_empty, tx_done, irq;
    logic       tick_d = 1'b0;
    bit         mon_on = 1'b0;
    int         n_chk = 0, n_fail = 0;
    logic       eq[$];
    string      tq[$];

    uart_brk_tx uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .send_brk(send_brk), .lin_mode(lin_mode), .word9(word9),
        .wr_valid(wr_valid), .wr_data(wr_data), .tdre_ie(tdre_ie),
        .tc_ie(tc_ie), .txd(txd), .txd_oe(txd_oe), .hold_empty(hold_empty),
        .tx_done(tx_done), .irq(irq)
    );

    initial forever #(CLK_P/2) clk = ~clk;

    // bit tick generator: one pulse every TPB clocks
    initial forever begin
        repeat (TPB-1) @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    end

    always @(posedge clk) tick_d <= bit_tick;

    task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: one line sample per bit period, compared against the scoreboard
    always @(negedge clk) begin
        if (mon_on && rst_n && tick_d) begin
            if (eq.size() > 0) begin
                logic  e;
                string t;
                e = eq.pop_front();
                t = tq.pop_front();
                chk(t, {8'd0, txd}, {8'd0, e});
            end else begin
                chk("R12 idle line", {8'd0, txd}, 9'd1);
            end
        end
    end

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            wait (bit_tick == 1'b1);
            @(negedge clk);
        end
    endtask

    task automatic mid();
        ticks(1);
        @(negedge clk);
    endtask

    task automatic push_data(logic [8:0] d, bit w9, string tag);
        eq.push_back(1'b0); tq.push_back({tag, " start"});
        for (int i = 0; i < (w9 ? 9 : 8); i++) begin
            eq.push_back(d[i]); tq.push_back({tag, " data"});
        end
        eq.push_back(1'b1); tq.push_back({tag, " stop"});
    endtask

    task automatic push_brk(bit lin, bit w9, string tag);
        int len;
        len = (w9 ? 11 : 10) + (lin ? 3 : 0);
        for (int i = 0; i < len; i++) begin
            eq.push_back(1'b0); tq.push_back({tag, " break low"});
        end
        eq.push_back(1'b1); tq.push_back({tag, " break stop"});
    endtask

    task automatic push_pre(bit w9, string tag);
        for (int i = 0; i < (w9 ? 11 : 10); i++) begin
            eq.push_back(1'b1); tq.push_back({tag, " preamble"});
        end
    endtask

    task automatic wr(logic [8:0] d);
        wr_data  = d;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic drain();
        while (eq.size() != 0) @(negedge clk);
        ticks(2);
    endtask

    task automatic pulse_brk();
        send_brk = 1'b1;
        @(negedge clk);
        send_brk = 1'b0;
    endtask

    task automatic pulse_en();
        tx_en = 1'b0;
        @(negedge clk);
        tx_en = 1'b1;
    endtask

    // watchdog
    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL R12 watchdog expired: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (12) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 reset hold_empty", {8'd0, hold_empty}, 9'd1);
        chk("R9 reset tx_done", {8'd0, tx_done}, 9'd1);
        chk("R9 reset txd", {8'd0, txd}, 9'd1);
        chk("R10 reset irq", {8'd0, irq}, 9'd0);
        chk("R6 oe follows enable", {8'd0, txd_oe}, 9'd1);
        mon_on = 1'b1;

        // R1 / R8: single 8-bit word, then a second word written mid-frame
        mid();
        push_data(9'h0A5, 1'b0, "R1");
        wr(9'h0A5);
        chk("R8 write clears empty", {8'd0, hold_empty}, 9'd0);
        chk("R8 write clears done", {8'd0, tx_done}, 9'd0);
        ticks(1);
        chk("R8 empty after take", {8'd0, hold_empty}, 9'd1);
        mid();
        push_data(9'h03C, 1'b0, "R1");
        wr(9'h03C);
        chk("R9 not done mid-frame", {8'd0, tx_done}, 9'd0);
        drain();
        chk("R9 done after last stop", {8'd0, tx_done}, 9'd1);

        // R1: 9-bit word
        word9 = 1'b1;
        mid();
        push_data(9'h1C3, 1'b1, "R1");
        wr(9'h1C3);
        drain();
        word9 = 1'b0;

        // R2 / R3: break lengths for each mode and word length
        for (int m = 0; m < 4; m++) begin
            mid();
            lin_mode = m[1];
            word9    = m[0];
            push_brk(m[1], m[0], m[1] ? "R3" : "R2");
            pulse_brk();
            drain();
        end
        lin_mode = 1'b0;
        word9    = 1'b0;

        // R4: break pulse during a data frame
        mid();
        push_data(9'h05A, 1'b0, "R4");
        wr(9'h05A);
        ticks(3);
        mid();
        push_brk(1'b0, 1'b0, "R4");
        pulse_brk();
        drain();

        // R5: held break repeats; none after release
        mid();
        push_brk(1'b0, 1'b0, "R5");
        push_brk(1'b0, 1'b0, "R5");
        send_brk = 1'b1;
        ticks(12);
        send_brk = 1'b0;
        drain();
        ticks(3);

        // R6: disabled transmitter tri-states and starts nothing
        mid();
        tx_en = 1'b0;
        @(negedge clk);
        chk("R6 oe low when disabled", {8'd0, txd_oe}, 9'd0);
        wr(9'h077);
        ticks(3);
        chk("R6 no start while disabled", {8'd0, hold_empty}, 9'd0);
        mid();
        push_data(9'h077, 1'b0, "R6");
        tx_en = 1'b1;
        drain();
        chk("R6 oe high when enabled", {8'd0, txd_oe}, 9'd1);

        // R7: enable pulse during a frame queues a preamble
        mid();
        push_data(9'h011, 1'b0, "R7");
        wr(9'h011);
        ticks(2);
        mid();
        push_pre(1'b0, "R7");
        pulse_en();
        drain();

        // R11: break, preamble and data all waiting at one boundary
        mid();
        push_data(9'h0C8, 1'b0, "R11");
        wr(9'h0C8);
        ticks(2);
        mid();
        push_brk(1'b0, 1'b0, "R11");
        push_pre(1'b0, "R11");
        push_data(9'h0E1, 1'b0, "R11");
        wr(9'h0E1);
        pulse_brk();
        pulse_en();
        drain();

        // R10: interrupt combinations
        tdre_ie = 1'b1;
        @(negedge clk);
        chk("R10 empty interrupt", {8'd0, irq}, 9'd1);
        tdre_ie = 1'b0;
        tc_ie   = 1'b1;
        @(negedge clk);
        chk("R10 complete interrupt", {8'd0, irq}, 9'd1);
        mid();
        push_data(9'h00F, 1'b0, "R10");
        wr(9'h00F);
        chk("R10 complete irq cleared by write", {8'd0, irq}, 9'd0);
        drain();
        chk("R10 complete irq after frame", {8'd0, irq}, 9'd1);
        tc_ie = 1'b0;
        @(negedge clk);
        chk("R10 masked", {8'd0, irq}, 9'd0);

        ticks(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule